// File: doc/BRIEF.md
# Tag-Filtered Capture Controller with Parity

This block sits between a deserializer and a capture FIFO. Each incoming 16-bit word comes with a 2-bit tag. A per-tag flag mask decides two things for each word: whether it opens a capture, and whether it is written out. Once a capture is open, every word whose tag carries a save flag is passed to a valid/data write port. Before it is written, the word's two top bits can be replaced by parity computed over its odd-numbered and its even-numbered payload bits.

Software loads the mask, the parity settings, a continuous flag and a stop count. It then pulses a set request to raise the run bit. In counted mode, hardware drops the run bit once the programmed number of words has been stored, so software can poll the bit to see when the capture is finished. In continuous mode the count is ignored, and capture goes on until software pulses the clear request. For two channels, instantiate the block twice.

Top module: `tagcap_ctrl`

## Requirements
- R1: Mask bit 2n is the save flag of tag value n and mask bit 2n+1 is its start flag (tag 0 uses bits 1:0, tag 3 uses bits 7:6).
- R2: After a set request, no word is stored until a word with a start-flagged tag arrives. That start word is itself stored only when its own save flag is also set. From then until run drops, every save-flagged word is stored.
- R3: A mask of 0xFF stores every valid word from the first one after the set request. A mask of 0x00 stores no word.
- R4: With parity enabled, output bit 15 is the XOR of data bits 1,3,5,7,9,11,13 and output bit 14 is the XOR of data bits 0,2,4,6,8,10,12. When odd parity is selected, both bits are inverted. Output bits 13:0 always equal input bits 13:0.
- R5: With parity disabled, output bits 15:14 are 0.
- R6: A set request makes run read 1 at the next cycle. It also loads the stop counter and clears the capture-open state.
- R7: In counted mode, each stored word decrements the counter. In the cycle after the counter reaches zero, run clears and no word is stored. A stop count of 0 clears run one cycle after the set request, with nothing stored.
- R8: In continuous mode the stop count is ignored, and words keep being stored until a clear request arrives.
- R9: A clear request makes run read 0 at the next cycle. A clear request wins over a set request in the same cycle. No word is stored while run is 0.
- R10: A stored word appears on wr_valid/wr_data exactly one cycle after the cycle in which it was presented.
- R11: After reset, run and wr_valid are 0.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Deserializer word valid |
| in_tag | input | 2 | Tag of the incoming word |
| in_data | input | 16 | Incoming word |
| cfg_tag_mask | input | 8 | Per-tag save (even bit) and start (odd bit) flags |
| cfg_par_en | input | 1 | Replace bits 15:14 with parity |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_cont | input | 1 | Continuous mode, stop count ignored |
| cfg_stop_cnt | input | 8 | Number of words to store in counted mode |
| sw_start_set | input | 1 | One-cycle request to raise run |
| sw_start_clr | input | 1 | One-cycle request to drop run |
| run | output | 1 | Run bit, cleared by hardware at the end of a counted capture |
| wr_valid | output | 1 | Write strobe toward the FIFO |
| wr_data | output | 16 | Word written toward the FIFO |

## Verification
Some rules are checked by the assertions on every cycle. A write only ever follows a cycle in which run was set and the tag had a save flag. Disabled parity always gives zero top bits. An exhausted counter or a clear request always drops run on the next edge. Other rules need the bench's scenarios with a reference model. These are the gating of saves until a start tag is seen, whether a start word is kept, the exact parity values in both polarities, the exact number of words a counted capture stores, and the precedence of clear over set.

// File: rtl/tagcap_pkg.sv
// Shared types for the tag-filtered capture controller.
// Assumes tags index a flag mask holding two bits per tag value.
package tagcap_pkg;
    typedef struct packed {
        logic start;
        logic save;
    } tag_flags_t;
endpackage

// File: rtl/tagcap_decode.sv
// Tag decoder: picks the save flag (even bit) and the start flag (odd bit)
// for the received tag out of the mask.
// Assumes the mask holds exactly two bits per tag value.
module tagcap_decode
    import tagcap_pkg::*;
#(
    parameter int TAG_W  = 2,
    localparam int MASK_W = 2 << TAG_W
) (
    input  logic [MASK_W-1:0] mask,
    input  logic [TAG_W-1:0]  tag,
    output tag_flags_t        flags
);
    // Index the mask pair that belongs to this tag.
    always_comb begin
        flags.save  = mask[{tag, 1'b0}];
        flags.start = mask[{tag, 1'b1}];
    end
endmodule

// File: rtl/tagcap_parity.sv
// Parity inserter: replaces the two top bits of a word with parity over the
// odd-numbered (top bit) and even-numbered (next bit) payload bits.
// Assumes DATA_W >= 4. Parity disabled forces both bits to zero.
module tagcap_parity #(
    parameter int DATA_W    = 16,
    localparam int PAYLOAD_W = DATA_W - 2
) (
    input  logic [DATA_W-1:0] din,
    input  logic              par_en,
    input  logic              par_odd,
    output logic [DATA_W-1:0] dout
);
    logic [PAYLOAD_W-1:0] odd_lane;
    logic [PAYLOAD_W-1:0] even_lane;

    // Split payload bits into odd-index and even-index lanes.
    for (genvar i = 0; i < PAYLOAD_W; i++) begin : g_lane
        if (i % 2 == 1) begin : g_odd
            assign odd_lane[i]  = din[i];
            assign even_lane[i] = 1'b0;
        end else begin : g_even
            assign odd_lane[i]  = 1'b0;
            assign even_lane[i] = din[i];
        end
    end

    // Reduce lanes, apply polarity and the enable.
    always_comb begin
        dout[PAYLOAD_W-1:0] = din[PAYLOAD_W-1:0];
        dout[DATA_W-1]      = par_en & ((^odd_lane) ^ par_odd);
        dout[DATA_W-2]      = par_en & ((^even_lane) ^ par_odd);
    end
endmodule

// File: rtl/tagcap_seq.sv
// Capture sequencer: holds the run bit, the capture-open flag and the stop
// counter, and decides which words are stored.
// Assumes set/clear arrive as single-cycle pulses; clear wins over set.
module tagcap_seq
    import tagcap_pkg::*;
#(
    parameter int STOP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_set,
    input  logic              req_clr,
    input  logic              cont,
    input  logic [STOP_W-1:0] stop_cnt,
    input  logic              word_valid,
    input  tag_flags_t        flags,
    output logic              run,
    output logic              store
);
    localparam logic [STOP_W-1:0] CNT_ZERO = '0;

    logic              armed_q;
    logic [STOP_W-1:0] cnt_q;
    logic              exhausted;
    logic              armed_next;

    // Counted mode ends once the counter has drained.
    assign exhausted  = !cont && (cnt_q == CNT_ZERO);
    assign armed_next = armed_q | flags.start;

    // A word is stored only while running, with the capture open and the tag's save flag set.
    always_comb begin
        store = run && !req_clr && !req_set && !exhausted
                && word_valid && armed_next && flags.save;
    end

    // Run bit, capture-open flag and stop counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            armed_q <= 1'b0;
            cnt_q   <= CNT_ZERO;
        end else if (req_clr) begin
            run <= 1'b0;
        end else if (req_set) begin
            run     <= 1'b1;
            armed_q <= 1'b0;
            cnt_q   <= stop_cnt;
        end else if (run) begin
            if (exhausted) begin
                run <= 1'b0;
            end else if (word_valid) begin
                armed_q <= armed_next;
                if (store && !cont) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cont && cnt_q == CNT_ZERO && !req_set) |=> !run); // R7
    AST_CLR_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        req_clr |=> !run); // R9
    AST_SET_RAISES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_set && !req_clr) |=> run); // R6
endmodule

// File: rtl/tagcap_ctrl.sv
// Top: tag-filtered capture controller. Decodes the tag, sequences the
// capture, inserts parity and registers the write toward the FIFO.
// Assumes one word per cycle at most and a FIFO that always accepts.
module tagcap_ctrl
    import tagcap_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 2,
    parameter int STOP_W = 8,
    localparam int MASK_W = 2 << TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_data,
    input  logic [MASK_W-1:0] cfg_tag_mask,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_cont,
    input  logic [STOP_W-1:0] cfg_stop_cnt,
    input  logic              sw_start_set,
    input  logic              sw_start_clr,
    output logic              run,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data
);
    tag_flags_t        flags;
    logic              store;
    logic [DATA_W-1:0] word_par;

    tagcap_decode #(.TAG_W(TAG_W)) u_decode (
        .mask  (cfg_tag_mask),
        .tag   (in_tag),
        .flags (flags)
    );

    tagcap_seq #(.STOP_W(STOP_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_set    (sw_start_set),
        .req_clr    (sw_start_clr),
        .cont       (cfg_cont),
        .stop_cnt   (cfg_stop_cnt),
        .word_valid (in_valid),
        .flags      (flags),
        .run        (run),
        .store      (store)
    );

    tagcap_parity #(.DATA_W(DATA_W)) u_parity (
        .din     (in_data),
        .par_en  (cfg_par_en),
        .par_odd (cfg_par_odd),
        .dout    (word_par)
    );

    // Register the write port toward the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_valid <= store;
            if (store) begin
                wr_data <= word_par;
            end
        end
    end

    AST_WRITE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(run)); // R9
    AST_WRITE_NEEDS_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(in_valid && cfg_tag_mask[{in_tag, 1'b0}])); // R1
    AST_PARITY_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(!cfg_par_en)) |-> (wr_data[DATA_W-1:DATA_W-2] == 2'b00)); // R5
endmodule

// File: tb/tagcap_ctrl_test.sv
`timescale 1ns/1ps
module tagcap_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_tag = '0;
    logic [15:0] in_data = '0;
    logic [7:0]  cfg_tag_mask = '0;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic        cfg_cont = 1'b0;
    logic [7:0]  cfg_stop_cnt = '0;
    logic        sw_start_set = 1'b0;
    logic        sw_start_clr = 1'b0;
    logic        run;
    logic        wr_valid;
    logic [15:0] wr_data;

    int checks = 0;
    int errors = 0;
    logic [15:0] expq[$];
    string       tagq[$];

    // reference model state
    logic       m_run = 1'b0;
    logic       m_armed = 1'b0;
    logic [7:0] m_cnt = '0;

    tagcap_ctrl uut (.*);

    always #10 clk = ~clk;

    function automatic logic [15:0] exp_word(input logic [15:0] d);
        logic po = 1'b0;
        logic pe = 1'b0;
        for (int i = 0; i < 14; i++) begin
            if (i % 2 == 1) po ^= d[i];
            else            pe ^= d[i];
        end
        if (!cfg_par_en) return {2'b00, d[13:0]};
        return {po ^ cfg_par_odd, pe ^ cfg_par_odd, d[13:0]};
    endfunction

    // One cycle of stimulus; the model predicts the design's next state.
    task automatic step(input logic v, input logic [1:0] t, input logic [15:0] d,
                        input logic s, input logic c, input string rq);
        logic st;
        logic sv;
        logic an;
        in_valid = v; in_tag = t; in_data = d; sw_start_set = s; sw_start_clr = c;
        if (c) m_run = 1'b0;
        else if (s) begin m_run = 1'b1; m_armed = 1'b0; m_cnt = cfg_stop_cnt; end
        else if (m_run) begin
            if (!cfg_cont && m_cnt == 0) m_run = 1'b0;
            else if (v) begin
                st = cfg_tag_mask[2*t+1];
                sv = cfg_tag_mask[2*t];
                an = m_armed | st;
                m_armed = an;
                if (an && sv) begin
                    expq.push_back(exp_word(d));
                    tagq.push_back(rq);
                    if (!cfg_cont) m_cnt = m_cnt - 1;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0; sw_start_set = 1'b0; sw_start_clr = 1'b0;
    endtask

    task automatic check_run(input string rq);
        checks++;
        if (run !== m_run) begin
            errors++;
            $display("FAIL %s run: actual %0b expected %0b", rq, run, m_run);
        end
    endtask

    task automatic check_drained(input string rq);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL %s pending writes: actual %0d missing expected 0", rq, expq.size());
            expq.delete(); tagq.delete();
        end
    endtask

    // Monitor: pops the scoreboard on each write, one cycle after acceptance (R10).
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected write: actual %h expected none", wr_data);
            end else begin
                logic [15:0] e;
                string r;
                e = expq.pop_front();
                r = tagq.pop_front();
                if (wr_data !== e) begin
                    errors++;
                    $display("FAIL %s data: actual %h expected %h", r, wr_data, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        checks++;
        if (run !== 1'b0 || wr_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset: actual run=%0b wr_valid=%0b expected 0 0", run, wr_valid);
        end

        // R3 R7 R4: all-flags mask, counted 3, even parity
        cfg_tag_mask = 8'hFF; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        cfg_cont = 1'b0; cfg_stop_cnt = 8'd3;
        step(0, 0, 0, 1, 0, "R6");
        check_run("R6");
        for (int i = 0; i < 5; i++) begin
            step(1, 2'(i), 16'(i * 16'h9E37 + 16'h1234), 0, 0, "R4");
            check_run("R7");
        end
        step(0, 0, 0, 0, 0, "R7");
        check_drained("R7");

        // R1 R2 R4: tag1 start only, tag0 and tag2 save, odd parity, continuous
        cfg_tag_mask = 8'h19; cfg_par_odd = 1'b1; cfg_cont = 1'b1;
        step(0, 0, 0, 1, 0, "R6");
        step(1, 0, 16'hAAAA, 0, 0, "R2");
        step(1, 2, 16'h5555, 0, 0, "R2");
        step(1, 1, 16'hFFFF, 0, 0, "R2");
        step(1, 0, 16'h0F0F, 0, 0, "R1");
        step(1, 2, 16'hC3A5, 0, 0, "R1");
        step(1, 3, 16'h7777, 0, 0, "R1");
        step(1, 1, 16'h1357, 0, 0, "R1");
        step(0, 0, 0, 0, 0, "R1");
        check_drained("R2");
        check_run("R8");

        // R9: clear, then words while stopped store nothing
        cfg_tag_mask = 8'hFF;
        step(0, 0, 0, 0, 1, "R9");
        check_run("R9");
        for (int i = 0; i < 4; i++) step(1, 2'(i), 16'hBEEF, 0, 0, "R9");
        check_drained("R9");

        // R9: clear wins over set
        step(0, 0, 0, 1, 1, "R9");
        check_run("R9");

        // R3: zero mask stores nothing
        cfg_tag_mask = 8'h00;
        step(0, 0, 0, 1, 0, "R3");
        for (int i = 0; i < 8; i++) step(1, 2'(i), 16'(i * 16'h1111), 0, 0, "R3");
        step(0, 0, 0, 0, 1, "R3");
        check_drained("R3");

        // R2: start tag without its save flag is not kept (tag3 start only, tag3 not save)
        cfg_tag_mask = 8'h85; cfg_cont = 1'b0; cfg_stop_cnt = 8'd2; cfg_par_en = 1'b0;
        step(0, 0, 0, 1, 0, "R6");
        step(1, 3, 16'hFACE, 0, 0, "R2");
        step(1, 0, 16'hFFFF, 0, 0, "R5");
        step(1, 1, 16'hC001, 0, 0, "R5");
        step(0, 0, 0, 0, 0, "R7");
        check_run("R7");
        step(0, 0, 0, 0, 0, "R7");
        check_run("R7");
        check_drained("R5");

        // R7: stop count 0 ends at once
        cfg_tag_mask = 8'hFF; cfg_stop_cnt = 8'd0;
        step(0, 0, 0, 1, 0, "R7");
        check_run("R7");
        step(1, 0, 16'h1111, 0, 0, "R7");
        check_run("R7");
        step(0, 0, 0, 0, 0, "R7");
        check_drained("R7");

        // R8: continuous ignores a small stop count
        cfg_cont = 1'b1; cfg_stop_cnt = 8'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        step(0, 0, 0, 1, 0, "R8");
        for (int i = 0; i < 300; i++) begin
            step(1, 2'(i), 16'(i * 16'h3D1B + 16'h0777), 0, 0, "R8");
        end
        check_run("R8");
        step(0, 0, 0, 0, 1, "R8");
        step(0, 0, 0, 0, 0, "R8");
        check_run("R9");
        check_drained("R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule